// File: doc/BRIEF.md
# Maskable Interrupt Enable and Pending Unit

This unit gathers five peripheral interrupt sources (cartridge, video, command, DMA channel one and DMA channel two) and drives one interrupt request line to the CPU. Each source gives a one-cycle event pulse. The pulse is stored in a pending bit. The request line is active when at least one pending bit is set and its enable bit is also set.

Software reaches the unit through a small register bus with an address, a write strobe, write data and combinational read data. There are two 32-bit registers: an enable mask and a pending word. A pending bit is cleared by writing a one to it. Bits that are written with zero keep their value, so software needs no read-modify-write sequence to acknowledge a single source. The same bit layout is used in both registers. Position 3 is not implemented.

Top module: `intr_gate`

## Requirements
- R1: Writing the register at byte offset 0x00 stores the enable mask for positions 0, 1, 2, 4 and 5. A later read of offset 0x00 returns the stored mask.
- R2: The pending register is at byte offset 0x04. Source bit positions are: cartridge = bit 0, video = bit 1, command = bit 2, DMA channel one = bit 4, DMA channel two = bit 5. The same positions apply to the enable register at 0x00. `src_evt` index k (0..4) is the sources in that order.
- R3: An event pulse sets its pending bit on the next clock edge, whether or not its enable bit is set.
- R4: Writing to offset 0x04 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R5: When an event and a write-1 clear hit the same pending bit in the same cycle, the bit is set after the edge.
- R6: `cpu_irq` is high exactly when some implemented position has both its pending and enable bits set.
- R7: Bits 31 to 6 and bit 3 of both registers always read 0 and ignore writes. A write to one register leaves the other register unchanged.
- R8: After reset both registers read 0 and `cpu_irq` is low.
- R9: Reads of any other offset return 0. Writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| src_evt | input | 5 | Event pulses: cartridge, video, command, DMA 1, DMA 2 |
| cpu_irq | output | 1 | Combined masked interrupt request |

## Verification
Directed cases come first. An event with its mask clear must set pending but keep `cpu_irq` low, which separates latching from masking. A clear and an event on the same bit in one cycle shows which of the two wins. Writes of all ones show whether reserved positions and unmapped offsets are really ignored. After that, a fixed-seed random mix of writes to both registers and to unused offsets is run together with sparse event pulses. After every cycle both registers and `cpu_irq` are compared against a bench model. This catches mixed-up bit positions, a register that also writes its neighbour, and clears that affect the wrong bits.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
   localparam int SRC_N   = 5;
   localparam int RSV_POS = 3;
   localparam int USED_W  = SRC_N + 1;

   function automatic int src_pos(input int idx);
      return (idx >= RSV_POS) ? idx + 1 : idx;
   endfunction

   function automatic logic [31:0] used_mask();
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < SRC_N; i++) m[src_pos(i)] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/intr_gate_dec.sv
module intr_gate_dec #(
   parameter int ADDR_W   = 8,
   parameter int ENA_OFS  = 0,
   parameter int PEND_OFS = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output logic              sel_ena,
   output logic              sel_pend,
   output logic              wr_ena,
   output logic              wr_pend
);
   localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(ENA_OFS);
   localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);

   always_comb begin
      sel_ena  = (addr == ENA_A);
      sel_pend = (addr == PEND_A);
      wr_ena   = we & sel_ena;
      wr_pend  = we & sel_pend;
   end
endmodule

// File: rtl/intr_gate_slice.sv
module intr_gate_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic wr_ena,
   input  logic wr_pend,
   input  logic wbit,
   output logic ena_q,
   output logic pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_ena) ena_q <= wbit;
         if (evt)
            pend_q <= 1'b1;
         else if (wr_pend && wbit)
            pend_q <= 1'b0;
      end
   end

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> pend_q); // R3
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && wr_pend && wbit) |=> pend_q); // R5
   AST_W1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && wr_pend && wbit) |=> !pend_q); // R4
   AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && !(wr_pend && wbit)) |=> $stable(pend_q)); // R4
   AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ena |=> $stable(ena_q)); // R7
endmodule

// File: rtl/intr_gate.sv
module intr_gate
   import intr_gate_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int ENA_OFS  = 0,
   parameter int PEND_OFS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [SRC_N-1:0]  src_evt,
   output logic              cpu_irq
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'(used_mask());

   if (DATA_W < USED_W) begin : g_bad_width
      $error("DATA_W too narrow for the source map");
   end
   if (ENA_OFS == PEND_OFS) begin : g_bad_ofs
      $error("register offsets collide");
   end
   if ((ENA_OFS % 4) != 0 || (PEND_OFS % 4) != 0) begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (ENA_OFS >= (1 << ADDR_W) || PEND_OFS >= (1 << ADDR_W)) begin : g_bad_range
      $error("register offset outside address range");
   end

   logic sel_ena, sel_pend, wr_ena, wr_pend;
   logic [SRC_N-1:0]  ena_s, pend_s;
   logic [DATA_W-1:0] ena_word, pend_word;

   intr_gate_dec #(
      .ADDR_W(ADDR_W), .ENA_OFS(ENA_OFS), .PEND_OFS(PEND_OFS)
   ) u_dec (
      .addr(bus_addr), .we(bus_we),
      .sel_ena(sel_ena), .sel_pend(sel_pend),
      .wr_ena(wr_ena), .wr_pend(wr_pend)
   );

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      localparam int P = src_pos(i);
      intr_gate_slice u_slice (
         .clk(clk), .rst_n(rst_n), .evt(src_evt[i]),
         .wr_ena(wr_ena), .wr_pend(wr_pend), .wbit(bus_wdata[P]),
         .ena_q(ena_s[i]), .pend_q(pend_s[i])
      );
   end

   always_comb begin
      ena_word  = '0;
      pend_word = '0;
      for (int i = 0; i < SRC_N; i++) begin
         ena_word[src_pos(i)]  = ena_s[i];
         pend_word[src_pos(i)] = pend_s[i];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_ena)  bus_rdata = ena_word;
      if (sel_pend) bus_rdata = pend_word;
   end

   assign cpu_irq = |(ena_s & pend_s);

   AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~MASK) == '0); // R7
   AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (ena_word != '0)); // R6
   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (pend_word != '0)); // R6
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ena && !sel_pend) |-> bus_rdata == '0); // R9
endmodule

// File: tb/intr_gate_bench.sv
module intr_gate_bench;
   localparam logic [31:0] MASK = 32'h0000_0037;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  src_evt = '0;
   logic        cpu_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [31:0] en_m = '0, pd_m = '0;

   always #10 clk = ~clk;

   intr_gate u_intr_gate (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
      .cpu_irq(cpu_irq)
   );

   function automatic logic [31:0] evt_word(input logic [4:0] e);
      return {26'd0, e[4], e[3], 1'b0, e[2], e[1], e[0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cycle(input logic [7:0] a, input logic we, input logic [31:0] d, input logic [4:0] e);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = d; src_evt = e;
      @(posedge clk);
      if (we && a == 8'h00) en_m = d & MASK;
      pd_m = (pd_m & ~((we && a == 8'h04) ? (d & MASK) : 32'h0)) | evt_word(e);
      @(negedge clk);
      bus_we = 1'b0; src_evt = '0;
   endtask

   task automatic peek(input string tag);
      bus_addr = 8'h00; #1 check({tag, " R1 enable"}, bus_rdata, en_m);
      bus_addr = 8'h04; #1 check({tag, " R2 pending"}, bus_rdata, pd_m);
      check({tag, " R6 irq"}, {31'd0, cpu_irq}, {31'd0, |(en_m & pd_m)});
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      peek("R8 reset");
      rst_n = 1'b1;
      // R3: event with mask off latches, no irq
      cycle(8'h00, 1'b0, 32'h0, 5'b01000);
      peek("R3 dma1 unmasked");
      check("R3 bit4 set", pd_m & 32'h10, 32'h10);
      // R7: all ones to enable, reserved read zero, pending untouched
      cycle(8'h00, 1'b1, 32'hFFFF_FFFF, 5'b0);
      peek("R7 enable ones");
      bus_addr = 8'h00; #1 check("R7 reserved", bus_rdata, 32'h37);
      // R4: write 0 keeps, write 1 clears
      cycle(8'h04, 1'b1, 32'h0, 5'b0);
      peek("R4 write zero");
      cycle(8'h04, 1'b1, 32'h10, 5'b0);
      peek("R4 write one");
      // R5: clear and set together
      cycle(8'h04, 1'b1, 32'h01, 5'b00001);
      peek("R5 collision");
      check("R5 bit0 kept", pd_m & 32'h1, 32'h1);
      // R9: unmapped offset
      cycle(8'h08, 1'b1, 32'hFFFF_FFFF, 5'b0);
      bus_addr = 8'h08; #1 check("R9 unmapped read", bus_rdata, 32'h0);
      peek("R9 regs kept");
      // R2: each source to its position
      cycle(8'h04, 1'b1, 32'hFFFF_FFFF, 5'b0);
      for (int k = 0; k < 5; k++) begin
         cycle(8'h00, 1'b0, 32'h0, 5'(1 << k));
         peek("R2 map");
         cycle(8'h04, 1'b1, 32'hFFFF_FFFF, 5'b0);
      end
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] a;
         logic [4:0] e;
         case ($urandom % 4)
            0: a = 8'h00;
            1: a = 8'h04;
            2: a = 8'h04;
            default: a = 8'($urandom);
         endcase
         e = 5'($urandom) & 5'($urandom);
         cycle(a, 1'($urandom), $urandom, e);
         peek("R6 random");
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule